// File: doc/BRIEF.md
# Sticky Interrupt Flag Register with Zero-Write Clear

This block holds one byte of interrupt request state for a group of on-chip peripherals. Seven bits are sticky flags. Each flag is raised by a single-cycle event pulse and stays raised until software writes a 0 into that bit position. Writing a 1 into a flag position does nothing, so software can clear exactly the flags it has serviced with a single byte write, and cannot lose events that arrive meanwhile. The remaining bit is plain read/write storage.

The register sits on a simple byte-wide bus at a fixed decode address, 0xF7 by default. Reads are combinational and have no side effects. A timer-width select decides which compare events feed the two timer F flags. In split 8-bit operation each half has its own match. In joined 16-bit operation only the joined match counts, and it lands in the upper flag. The block drives one combined interrupt request, which is the OR of the seven flags.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset all eight register bits read 0 and `irq_req` is 0.
- R2: A pulse sets its flag at the next clock edge, and the flag stays set with no further pulse. The bit positions are: 7 direct transition, 6 A/D done, 4 timer G edge, 3 timer FH, 2 timer FL, 1 timer C, 0 asynchronous counter overflow.
- R3: A bus write to the register address with a 0 in a flag position clears that flag. A 1 in a flag position leaves that flag unchanged.
- R4: Bit 5 takes the written value on every register write. Bit 5 never affects `irq_req`.
- R5: With `tmrf_wide`=0, `ev_fh_match` sets bit 3 and `ev_fl_match` sets bit 2. `ev_f16_match` is ignored.
- R6: With `tmrf_wide`=1, `ev_f16_match` sets bit 3. `ev_fh_match` and `ev_fl_match` are ignored.
- R7: The timer C flag (bit 1) is set by `ev_tc_ovf` and also by `ev_tc_unf`.
- R8: When a flag's set pulse and a zero-write to that flag fall in the same cycle, the flag ends up set.
- R9: `irq_req` is 1 exactly when at least one of bits 7, 6, 4..0 is set.
- R10: Writes to any other address change nothing. Reads of any other address return 0. Reading has no side effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents when address matches, else 0 |
| tmrf_wide | input | 1 | Timer F width select: 0 two 8-bit halves, 1 joined 16-bit |
| ev_direct | input | 1 | Direct transition event pulse |
| ev_adc_done | input | 1 | A/D conversion complete pulse |
| ev_tg_edge | input | 1 | Timer G capture edge pulse |
| ev_fh_match | input | 1 | Timer FH 8-bit compare match pulse |
| ev_fl_match | input | 1 | Timer FL 8-bit compare match pulse |
| ev_f16_match | input | 1 | Joined 16-bit timer F compare match pulse |
| ev_tc_ovf | input | 1 | Timer C overflow pulse |
| ev_tc_unf | input | 1 | Timer C underflow pulse |
| ev_async_ovf | input | 1 | Asynchronous counter overflow pulse |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The two functions that can meet in one cycle are a peripheral raising a flag and software clearing that same flag with a zero-write. The bench provokes this by driving a set pulse together with a register write whose data has 0 in that bit. It also drives the same kind of write against a neighbouring flag. It then reads back one cycle later and expects the pulsed flag set and the neighbour cleared. The scoreboard also compares the combined request after each such collision.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned B_DIR   = 7;
   localparam int unsigned B_ADC   = 6;
   localparam int unsigned B_STORE = 5;
   localparam int unsigned B_TG    = 4;
   localparam int unsigned B_FH    = 3;
   localparam int unsigned B_FL    = 2;
   localparam int unsigned B_TC    = 1;
   localparam int unsigned B_ASY   = 0;
   localparam logic [REG_W-1:0] FLAG_MASK = 8'b1101_1111;

   typedef enum logic {CELL_FLAG = 1'b0, CELL_STORE = 1'b1} cell_kind_e;
endpackage

// File: rtl/irqf_src_map.sv
module irqf_src_map
   import irqf_pkg::*;
(
   input  logic             tmrf_wide,
   input  logic             ev_direct,
   input  logic             ev_adc_done,
   input  logic             ev_tg_edge,
   input  logic             ev_fh_match,
   input  logic             ev_fl_match,
   input  logic             ev_f16_match,
   input  logic             ev_tc_ovf,
   input  logic             ev_tc_unf,
   input  logic             ev_async_ovf,
   output logic [REG_W-1:0] set_vec
);
   always_comb begin
      set_vec          = '0;
      set_vec[B_DIR]   = ev_direct;
      set_vec[B_ADC]   = ev_adc_done;
      set_vec[B_TG]    = ev_tg_edge;
      set_vec[B_FH]    = tmrf_wide ? ev_f16_match : ev_fh_match;
      set_vec[B_FL]    = ~tmrf_wide & ev_fl_match;
      set_vec[B_TC]    = ev_tc_ovf | ev_tc_unf;
      set_vec[B_ASY]   = ev_async_ovf;
   end
endmodule

// File: rtl/irqf_cell.sv
module irqf_cell
   import irqf_pkg::*;
#(
   parameter cell_kind_e KIND = CELL_FLAG
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wbit,
   input  logic set_ev,
   output logic q
);
   generate
      if (KIND == CELL_FLAG) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else if (set_ev)
               q <= 1'b1;
            else if (wr_hit && !wbit)
               q <= 1'b0;
         end
      end else begin : g_store
         logic unused_set;
         assign unused_set = set_ev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else if (wr_hit)
               q <= wbit;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import irqf_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [7:0]  REG_ADDR = 8'hF7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              tmrf_wide,
   input  logic              ev_direct,
   input  logic              ev_adc_done,
   input  logic              ev_tg_edge,
   input  logic              ev_fh_match,
   input  logic              ev_fl_match,
   input  logic              ev_f16_match,
   input  logic              ev_tc_ovf,
   input  logic              ev_tc_unf,
   input  logic              ev_async_ovf,
   output logic              irq_req
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("irq_flag_reg: ADDR_W must be at least 8");
      end
   endgenerate

   logic              hit;
   logic              wr_hit;
   logic [REG_W-1:0]  set_vec;
   logic [REG_W-1:0]  flags_q;

   assign hit    = (bus_addr == HIT_ADDR);
   assign wr_hit = bus_wr & hit;

   irqf_src_map u_src (
      .tmrf_wide   (tmrf_wide),
      .ev_direct   (ev_direct),
      .ev_adc_done (ev_adc_done),
      .ev_tg_edge  (ev_tg_edge),
      .ev_fh_match (ev_fh_match),
      .ev_fl_match (ev_fl_match),
      .ev_f16_match(ev_f16_match),
      .ev_tc_ovf   (ev_tc_ovf),
      .ev_tc_unf   (ev_tc_unf),
      .ev_async_ovf(ev_async_ovf),
      .set_vec     (set_vec)
   );

   generate
      for (genvar i = 0; i < REG_W; i++) begin : g_bit
         localparam cell_kind_e K = FLAG_MASK[i] ? CELL_FLAG : CELL_STORE;
         irqf_cell #(.KIND(K)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hit(wr_hit),
            .wbit  (bus_wdata[i]),
            .set_ev(set_vec[i]),
            .q     (flags_q[i])
         );
      end
   endgenerate

   assign bus_rdata = hit ? flags_q : '0;
   assign irq_req   = |(flags_q & FLAG_MASK);
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
   import irqf_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [7:0]  REG_ADDR = 8'hF7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  flags_q,
   input logic              irq_req,
   input logic              ev_direct,
   input logic              ev_adc_done,
   input logic              ev_tg_edge,
   input logic              ev_fh_match,
   input logic              ev_fl_match,
   input logic              ev_f16_match,
   input logic              ev_tc_ovf,
   input logic              ev_tc_unf,
   input logic              ev_async_ovf
);
   logic hit_w;
   logic any_ev;
   assign hit_w  = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));
   assign any_ev = ev_direct | ev_adc_done | ev_tg_edge | ev_fh_match | ev_fl_match |
                   ev_f16_match | ev_tc_ovf | ev_tc_unf | ev_async_ovf;

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_direct |=> flags_q[B_DIR]);
   a_r3_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_w && bus_wdata[B_ADC] && flags_q[B_ADC]) |=> flags_q[B_ADC]);
   a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_w && !bus_wdata[B_DIR] && !ev_direct) |=> !flags_q[B_DIR]);
   a_r4_store: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w |=> (flags_q[B_STORE] == $past(bus_wdata[B_STORE])));
   a_r10_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_w && !any_ev) |=> $stable(flags_q));
   a_r9_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & FLAG_MASK) == '0) |-> !irq_req);
endmodule

bind irq_flag_reg irqf_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .flags_q(flags_q), .irq_req(irq_req),
   .ev_direct(ev_direct), .ev_adc_done(ev_adc_done), .ev_tg_edge(ev_tg_edge),
   .ev_fh_match(ev_fh_match), .ev_fl_match(ev_fl_match), .ev_f16_match(ev_f16_match),
   .ev_tc_ovf(ev_tc_ovf), .ev_tc_unf(ev_tc_unf), .ev_async_ovf(ev_async_ovf)
);

// File: tb/sim_irq_flag_reg.sv
`timescale 1ns/1ps
module sim_irq_flag_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'hF7;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       tmrf_wide = 1'b0;
   logic [8:0] ev = '0;
   logic       irq_req;

   always #5 clk = ~clk;

   irq_flag_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmrf_wide(tmrf_wide),
      .ev_direct(ev[0]), .ev_adc_done(ev[1]), .ev_tg_edge(ev[2]),
      .ev_fh_match(ev[3]), .ev_fl_match(ev[4]), .ev_f16_match(ev[5]),
      .ev_tc_ovf(ev[6]), .ev_tc_unf(ev[7]), .ev_async_ovf(ev[8]),
      .irq_req(irq_req)
   );

   // event index: 0 dir,1 adc,2 tg,3 fh8,4 fl8,5 f16,6 tc_ovf,7 tc_unf,8 async
   localparam logic [8:0] E_DIR = 9'h001, E_ADC = 9'h002, E_TG = 9'h004,
                          E_FH = 9'h008, E_FL = 9'h010, E_F16 = 9'h020,
                          E_OVF = 9'h040, E_UNF = 9'h080, E_ASY = 9'h100;

   int         n_vec = 0;
   int         n_bad = 0;
   bit         done = 1'b0;
   logic [7:0] model = 8'h00;
   logic [7:0] q_data[$];
   logic       q_irq[$];
   string      q_req[$];

   function automatic logic [7:0] set_of(logic [8:0] e, logic wide);
      logic [7:0] s = 8'h00;
      s[7] = e[0];
      s[6] = e[1];
      s[4] = e[2];
      s[3] = wide ? e[5] : e[3];
      s[2] = !wide && e[4];
      s[1] = e[6] | e[7];
      s[0] = e[8];
      return s;
   endfunction

   task automatic apply(input logic [8:0] e, input logic wr, input logic [7:0] a,
                        input logic [7:0] wd, input string req);
      logic [7:0] s;
      @(posedge clk); #2;
      ev = e; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      s = set_of(e, tmrf_wide);
      if (wr && a == 8'hF7)
         model = (s | (model & wd & 8'hDF)) | (wd & 8'h20);
      else
         model = model | s;
      @(posedge clk); #2;
      ev = '0; bus_wr = 1'b0; bus_addr = 8'hF7; bus_wdata = 8'h00;
      q_data.push_back(model);
      q_irq.push_back(|(model & 8'hDF));
      q_req.push_back(req);
   endtask

   always @(negedge clk) begin
      if (q_data.size() > 0) begin
         logic [7:0] d;
         logic       i;
         string      r;
         d = q_data.pop_front();
         i = q_irq.pop_front();
         r = q_req.pop_front();
         n_vec++;
         if (bus_rdata !== d || irq_req !== i) begin
            n_bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", r, bus_rdata, irq_req, d, i);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      #23;
      n_vec++;
      if (bus_rdata !== 8'h00 || irq_req !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 in reset: rdata=%h irq=%b expected 00 0", bus_rdata, irq_req);
      end
      rst_n = 1'b1;
      apply('0, 1'b0, 8'hF7, 8'h00, "R1 idle after reset");
      // R2 each source, sticky
      apply(E_DIR, 1'b0, 8'hF7, 8'h00, "R2 direct bit7");
      apply('0, 1'b0, 8'hF7, 8'h00, "R2 sticky");
      apply(E_ADC, 1'b0, 8'hF7, 8'h00, "R2 adc bit6");
      apply(E_TG, 1'b0, 8'hF7, 8'h00, "R2 tg bit4");
      apply(E_ASY, 1'b0, 8'hF7, 8'h00, "R2 async bit0");
      // R3 write ones keep, zero clears
      apply('0, 1'b1, 8'hF7, 8'hDF, "R3 ones keep");
      apply('0, 1'b1, 8'hF7, 8'h7F, "R3 zero clears bit7");
      apply('0, 1'b1, 8'hF7, 8'h00, "R3 clear all");
      // R4 store bit
      apply('0, 1'b1, 8'hF7, 8'h20, "R4 bit5 set, irq low");
      apply('0, 1'b1, 8'hF7, 8'h00, "R4 bit5 cleared");
      // R5 narrow mode
      tmrf_wide = 1'b0;
      apply(E_F16, 1'b0, 8'hF7, 8'h00, "R5 joined match ignored");
      apply(E_FH, 1'b0, 8'hF7, 8'h00, "R5 fh sets bit3");
      apply(E_FL, 1'b0, 8'hF7, 8'h00, "R5 fl sets bit2");
      apply('0, 1'b1, 8'hF7, 8'h00, "R3 clear");
      // R6 wide mode
      tmrf_wide = 1'b1;
      apply(E_FH | E_FL, 1'b0, 8'hF7, 8'h00, "R6 halves ignored");
      apply(E_F16, 1'b0, 8'hF7, 8'h00, "R6 joined sets bit3");
      apply('0, 1'b1, 8'hF7, 8'h00, "R3 clear");
      tmrf_wide = 1'b0;
      // R7 timer C both directions
      apply(E_OVF, 1'b0, 8'hF7, 8'h00, "R7 overflow");
      apply('0, 1'b1, 8'hF7, 8'h00, "R3 clear");
      apply(E_UNF, 1'b0, 8'hF7, 8'h00, "R7 underflow");
      // R8 collision: set bit1 again while clearing bit1 and bit7
      apply(E_DIR, 1'b0, 8'hF7, 8'h00, "R2 direct again");
      apply(E_UNF, 1'b1, 8'hF7, 8'h00, "R8 set wins, neighbour cleared");
      apply(E_ADC, 1'b1, 8'hF7, 8'hBF, "R8 set wins with explicit zero");
      // R10 other address
      apply('0, 1'b1, 8'hF6, 8'h00, "R10 foreign write ignored");
      apply('0, 1'b1, 8'hF8, 8'h20, "R10 foreign write no bit5");
      @(posedge clk); #2;
      bus_addr = 8'h37;
      #1;
      n_vec++;
      if (bus_rdata !== 8'h00) begin
         n_bad++;
         $display("FAIL R10 foreign read: rdata=%h expected 00", bus_rdata);
      end
      bus_addr = 8'hF7;
      apply('0, 1'b0, 8'hF7, 8'h00, "R10 reads left state intact");
      // R9 each flag alone drives irq
      apply('0, 1'b1, 8'hF7, 8'h00, "R9 clear all, irq low");
      apply(E_TG, 1'b0, 8'hF7, 8'h00, "R9 single flag raises irq");
      apply('0, 1'b1, 8'hF7, 8'hEF, "R9 clear last flag, irq low");
      @(negedge clk); @(negedge clk);
      finish_run();
   end
endmodule